// File: doc/BRIEF.md
# Mode-Selectable Instruction Store

This block is the instruction store that sits right beside a processor core on a plain request/response bus. A request carries a select, a byte address, four byte enables, write data and a write strobe. Exactly one clock later the block answers with read data, an acknowledge or an error. It decodes its own address range, which starts at instruction-space address zero and spans a size in bytes set by a parameter. Requests outside that range get no answer from it, so another bus slave can answer them.

A single parameter picks how the array is built. When the loader-enable parameter is true, the array is a writable RAM with no initial contents. A loader can fill or replace the program at run time, one byte lane at a time if needed. When the parameter is false, the array is a ROM whose words come from a constant image parameter given at elaboration. There is no run-time load path in that mode. Any write inside the range gets an error response instead of an acknowledge, so the core can raise a store access fault. The stored words stay as they are.

Read data is zero in every cycle except the response cycle of a read. Several slaves can therefore have their read data ORed onto one return bus.

Top module: `instr_mem`

## Requirements
- R1: The block answers only requests whose byte address lies in [0, SIZE_BYTES). SIZE_BYTES is a power of two. The last word below SIZE_BYTES is reachable. Addresses at or above SIZE_BYTES, including high addresses, are outside the range.
- R2: Each in-range request sampled with the select high gets exactly one response pulse (acknowledge or error) in the next cycle. A cycle with the select low produces no response and does not change the contents.
- R3: A request outside the range produces neither acknowledge nor error, keeps read data zero and does not change any stored word. This includes a word whose index bits would alias.
- R4: In RAM mode, a write inside the range is acknowledged. A later read of the same word returns the written data with an acknowledge.
- R5: In RAM mode, byte-enable bit i controls data bits 8*i+7 down to 8*i. Only enabled lanes are updated and the other lanes keep their value.
- R6: The array is a ROM when LOADER_EN is 0 and a RAM when LOADER_EN is 1.
- R7: In ROM mode, a write inside the range returns an error and no acknowledge, with read data zero. The addressed word is left unchanged.
- R8: In ROM mode, word n (byte address 4*n) reads as bits 32*n+31 down to 32*n of ROM_IMAGE. Words at or beyond IMG_WORDS read as zero.
- R9: Read data is zero in every cycle that is not the response cycle of an in-range read. This includes write-response cycles and error cycles.
- R10: Acknowledge and error are never high in the same cycle.
- R11: While reset is held low, acknowledge, error and read data are zero, even with a request present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_sel | input | 1 | Request valid this cycle |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_rdata | output | 32 | Read data, zero outside read responses |
| rsp_ack | output | 1 | Successful completion pulse |
| rsp_err | output | 1 | Access-fault pulse (ROM-mode write) |

## Verification
The hardest case to reach from the ports is an out-of-range write whose index bits alias a live word. If the range decode were dropped, that write would silently overwrite stored data. The stimulus first writes a known pattern to word zero. It then writes zero to the first address past the range and reads word zero back. In ROM mode the bench issues two back-to-back writes to an image word, which checks that every request gets its own error pulse. It then reads the word to confirm the image survived. A second instance built with the loader disabled covers the ROM side.

// File: rtl/instr_mem_pkg.sv
// Shared definitions for the instruction store.
// Assumes a 32-bit data bus with four byte lanes.
package instr_mem_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // Array flavour chosen at elaboration.
    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_RAM = 1'b1
    } mem_mode_e;

    // Classified request for one cycle; at most one bit is set.
    typedef struct packed {
        logic rd;      // in-range read
        logic wr_ok;   // in-range write that the array accepts
        logic wr_bad;  // in-range write that must be rejected
    } acc_kind_t;

    // Expand byte enables into a bit mask over the data word.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/instr_mem_decode.sv
// Address range decode and request classification.
// Assumes SIZE_BYTES is a power of two, at least 8 and below 2**32.
// The range starts at byte address 0.
module instr_mem_decode
    import instr_mem_pkg::*;
#(
    parameter int SIZE_BYTES  = 1024,
    parameter bit ALLOW_WRITE = 1'b1,
    localparam int DEPTH = SIZE_BYTES / 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          sel,
    input  logic          we,
    input  logic [31:2]   word_addr,
    output acc_kind_t     kind,
    output logic [AW-1:0] idx
);
    logic in_range;

    // In range when every address bit above the array index is zero.
    always_comb begin
        in_range = (word_addr[31:AW+2] == '0);
        idx      = word_addr[AW+1:2];
    end

    // Split an in-range request into read, accepted write or rejected write.
    always_comb begin
        kind        = '0;
        kind.rd     = sel && in_range && !we;
        kind.wr_ok  = sel && in_range &&  we &&  ALLOW_WRITE;
        kind.wr_bad = sel && in_range &&  we && !ALLOW_WRITE;
    end
endmodule

// File: rtl/instr_mem_ram.sv
// Writable array with byte-lane writes and a registered read port.
// Assumes no reset and no initial contents; reads of unwritten words are undefined.
module instr_mem_ram
    import instr_mem_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     idx,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wmask;

    // Bit mask of the lanes this write may touch.
    always_comb wmask = lane_mask(be);

    // Merge enabled lanes into the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= (mem[idx] & ~wmask) | (wdata & wmask);
        end
    end

    // Registered read, aligned with the response cycle.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/instr_mem_rom.sv
// Read-only array whose contents come from a packed image parameter.
// Word n sits in bits 32*n+31:32*n; words at or beyond IMG_WORDS read as zero.
module instr_mem_rom
    import instr_mem_pkg::*;
#(
    parameter int                      DEPTH     = 256,
    parameter int                      IMG_WORDS = 4,
    parameter logic [IMG_WORDS*32-1:0] ROM_IMAGE = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [AW-1:0]     idx,
    output logic [DATA_W-1:0] q
);
    // Fetch one word of the image, zero past its end.
    function automatic logic [DATA_W-1:0] image_word(input int n);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < IMG_WORDS; k++) begin
            if (k == n) w = ROM_IMAGE[32*k +: 32];
        end
        return w;
    endfunction

    // Registered lookup, aligned with the response cycle.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            q <= image_word(int'(idx));
        end
    end
endmodule

// File: rtl/instr_mem_resp.sv
// Response stage: turns the classified request into one-cycle pulses.
// Assumes the array output q is valid in the cycle after a read.
module instr_mem_resp
    import instr_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         kind,
    input  logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err
);
    logic rd_valid;

    // Register the outcome of this cycle's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            ack      <= kind.rd | kind.wr_ok;
            err      <= kind.wr_bad;
            rd_valid <= kind.rd;
        end
    end

    // Gate read data so it can be OR-combined on a shared return bus.
    always_comb rdata = rd_valid ? q : '0;

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err)); // R10
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !kind.rd |=> (rdata == '0)); // R9
    AST_ERR_FROM_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        kind.wr_bad |=> (err && !ack)); // R7
endmodule

// File: rtl/instr_mem.sv
// Instruction store at the bottom of the instruction space.
// LOADER_EN=1 builds a writable RAM with no initial contents.
// LOADER_EN=0 builds a ROM from ROM_IMAGE that rejects writes with an error.
// Assumes SIZE_BYTES is a power of two; one-cycle response latency.
module instr_mem
    import instr_mem_pkg::*;
#(
    parameter int                      SIZE_BYTES = 1024,
    parameter bit                      LOADER_EN  = 1'b1,
    parameter int                      IMG_WORDS  = 4,
    parameter logic [IMG_WORDS*32-1:0] ROM_IMAGE  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_sel,
    input  logic [31:0] req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    input  logic        req_we,
    output logic [31:0] rsp_rdata,
    output logic        rsp_ack,
    output logic        rsp_err
);
    localparam int        DEPTH = SIZE_BYTES / 4;
    localparam int        AW    = $clog2(DEPTH);
    localparam mem_mode_e MODE  = LOADER_EN ? MODE_RAM : MODE_ROM;

    acc_kind_t         kind;
    logic [AW-1:0]     idx;
    logic [DATA_W-1:0] arr_q;
    logic              unused_lsb;

    // Byte offset within a word does not select anything.
    assign unused_lsb = ^req_addr[1:0];

    instr_mem_decode #(
        .SIZE_BYTES  (SIZE_BYTES),
        .ALLOW_WRITE (MODE == MODE_RAM)
    ) u_decode (
        .sel       (req_sel),
        .we        (req_we),
        .word_addr (req_addr[31:2]),
        .kind      (kind),
        .idx       (idx)
    );

    generate
        if (MODE == MODE_RAM) begin : g_ram
            instr_mem_ram #(.DEPTH(DEPTH)) u_ram (
                .clk   (clk),
                .wr_en (kind.wr_ok),
                .rd_en (kind.rd),
                .idx   (idx),
                .be    (req_be),
                .wdata (req_wdata),
                .q     (arr_q)
            );
        end else begin : g_rom
            logic unused_wr;
            // Write lanes have no destination in a ROM.
            assign unused_wr = ^{req_be, req_wdata, kind.wr_ok};

            instr_mem_rom #(
                .DEPTH     (DEPTH),
                .IMG_WORDS (IMG_WORDS),
                .ROM_IMAGE (ROM_IMAGE)
            ) u_rom (
                .clk   (clk),
                .rd_en (kind.rd),
                .idx   (idx),
                .q     (arr_q)
            );

            AST_ROM_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
                (req_sel && req_we && (kind != '0)) |=> (rsp_err && !rsp_ack)); // R7
        end
    endgenerate

    instr_mem_resp u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .q     (arr_q),
        .rdata (rsp_rdata),
        .ack   (rsp_ack),
        .err   (rsp_err)
    );

    AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != '0) |=> (rsp_ack || rsp_err)); // R2
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == '0) |=> (!rsp_ack && !rsp_err)); // R3
    AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(kind)); // R10
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_sel |=> (!rsp_ack && !rsp_err && rsp_rdata == '0)); // R2
endmodule

// File: tb/instr_mem_tb.sv
// Bench: a RAM instance (u_dut) walked through a vector table, then
// directed tests on a ROM instance, reset and corner cases.
module instr_mem_tb;
    localparam int            ROM_BYTES = 64;
    localparam logic [127:0]  IMAGE = {32'h2468ACE0, 32'h13579BDF, 32'h0BADC0DE, 32'hDEADBEEF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel [2];
    logic [31:0] addr [2];
    logic [3:0]  be [2];
    logic [31:0] wdata [2];
    logic        we [2];
    logic [31:0] rdata [2];
    logic        ack [2];
    logic        err [2];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    instr_mem #(.SIZE_BYTES(1024), .LOADER_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_sel(sel[0]), .req_addr(addr[0]),
        .req_be(be[0]), .req_wdata(wdata[0]), .req_we(we[0]),
        .rsp_rdata(rdata[0]), .rsp_ack(ack[0]), .rsp_err(err[0]));

    instr_mem #(.SIZE_BYTES(ROM_BYTES), .LOADER_EN(1'b0), .IMG_WORDS(4),
                .ROM_IMAGE(IMAGE)) u_dut_rom (
        .clk(clk), .rst_n(rst_n), .req_sel(sel[1]), .req_addr(addr[1]),
        .req_be(be[1]), .req_wdata(wdata[1]), .req_we(we[1]),
        .rsp_rdata(rdata[1]), .rsp_ack(ack[1]), .rsp_err(err[1]));

    typedef struct packed {
        logic [7:0]  req;
        logic        s;
        logic        w;
        logic [31:0] a;
        logic [3:0]  b;
        logic [31:0] d;
        logic        e_ack;
        logic        e_err;
        logic [31:0] e_rd;
    } vec_t;

    // RAM-mode table: req tag, sel, we, addr, be, wdata, ack, err, rdata.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 1'b1, 1'b1, 32'h000, 4'hF, 32'h11223344, 1'b1, 1'b0, 32'h0},        // R4
        '{8'd4, 1'b1, 1'b0, 32'h000, 4'hF, 32'h0,        1'b1, 1'b0, 32'h11223344}, // R4
        '{8'd5, 1'b1, 1'b1, 32'h000, 4'h5, 32'hAABBCCDD, 1'b1, 1'b0, 32'h0},        // R5
        '{8'd5, 1'b1, 1'b0, 32'h000, 4'hF, 32'h0,        1'b1, 1'b0, 32'h11BB33DD}, // R5
        '{8'd4, 1'b1, 1'b1, 32'h008, 4'hF, 32'h01020304, 1'b1, 1'b0, 32'h0},        // R4
        '{8'd5, 1'b1, 1'b1, 32'h008, 4'h8, 32'hFF000000, 1'b1, 1'b0, 32'h0},        // R5
        '{8'd5, 1'b1, 1'b0, 32'h008, 4'h0, 32'h0,        1'b1, 1'b0, 32'hFF020304}, // R5
        '{8'd1, 1'b1, 1'b1, 32'h3FC, 4'hF, 32'hCAFEF00D, 1'b1, 1'b0, 32'h0},        // R1
        '{8'd1, 1'b1, 1'b0, 32'h3FC, 4'hF, 32'h0,        1'b1, 1'b0, 32'hCAFEF00D}, // R1
        '{8'd3, 1'b1, 1'b1, 32'h400, 4'hF, 32'h0,        1'b0, 1'b0, 32'h0},        // R3
        '{8'd3, 1'b1, 1'b0, 32'h400, 4'hF, 32'h0,        1'b0, 1'b0, 32'h0},        // R3
        '{8'd3, 1'b1, 1'b0, 32'h000, 4'hF, 32'h0,        1'b1, 1'b0, 32'h11BB33DD}, // R3
        '{8'd2, 1'b0, 1'b1, 32'h000, 4'hF, 32'h0,        1'b0, 1'b0, 32'h0},        // R2
        '{8'd2, 1'b1, 1'b0, 32'h000, 4'hF, 32'h0,        1'b1, 1'b0, 32'h11BB33DD}, // R2
        '{8'd1, 1'b1, 1'b0, 32'h80000000, 4'hF, 32'h0,   1'b0, 1'b0, 32'h0}         // R1
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request on instance d, sample its response one cycle later.
    task automatic access(input int d, input string req, input logic s, input logic w,
                          input logic [31:0] a, input logic [3:0] b, input logic [31:0] wd,
                          input logic e_ack, input logic e_err, input logic [31:0] e_rd);
        sel[d] = s; we[d] = w; addr[d] = a; be[d] = b; wdata[d] = wd;
        @(negedge clk);
        check(req, "ack", {31'b0, ack[d]}, {31'b0, e_ack});
        check(req, "err", {31'b0, err[d]}, {31'b0, e_err});
        check(req, "rdata", rdata[d], e_rd);
        check("R10", "ack&err", {31'b0, ack[d] & err[d]}, 32'h0);
        sel[d] = 1'b0; we[d] = 1'b0;
    endtask

    task automatic idle_check(input int d, input string req);
        @(negedge clk);
        check(req, "idle ack", {31'b0, ack[d]}, 32'h0);
        check(req, "idle err", {31'b0, err[d]}, 32'h0);
        check(req, "idle rdata", rdata[d], 32'h0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            sel[d] = 1'b1; we[d] = 1'b0; addr[d] = 32'h0; be[d] = 4'hF; wdata[d] = 32'h0;
        end
        // R11: request present during reset, outputs stay quiet.
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check("R11", "reset ack", {31'b0, ack[d]}, 32'h0);
            check("R11", "reset err", {31'b0, err[d]}, 32'h0);
            check("R11", "reset rdata", rdata[d], 32'h0);
            sel[d] = 1'b0;
        end
        rst_n = 1'b1;
        @(negedge clk);

        // RAM vector table.
        for (int i = 0; i < NV; i++) begin
            access(0, $sformatf("R%0d", VECS[i].req), VECS[i].s, VECS[i].w, VECS[i].a,
                   VECS[i].b, VECS[i].d, VECS[i].e_ack, VECS[i].e_err, VECS[i].e_rd);
        end
        idle_check(0, "R9");

        // R6: loader enabled acknowledges a write; loader disabled rejects it.
        access(0, "R6", 1'b1, 1'b1, 32'h10, 4'hF, 32'h5A5A5A5A, 1'b1, 1'b0, 32'h0);
        access(1, "R6", 1'b1, 1'b1, 32'h0, 4'hF, 32'h5A5A5A5A, 1'b0, 1'b1, 32'h0);
        idle_check(1, "R2");

        // R8: image words, and words past the image read zero.
        access(1, "R8", 1'b1, 1'b0, 32'h0,  4'hF, 32'h0, 1'b1, 1'b0, 32'hDEADBEEF);
        access(1, "R8", 1'b1, 1'b0, 32'h4,  4'hF, 32'h0, 1'b1, 1'b0, 32'h0BADC0DE);
        access(1, "R8", 1'b1, 1'b0, 32'hC,  4'hF, 32'h0, 1'b1, 1'b0, 32'h2468ACE0);
        access(1, "R8", 1'b1, 1'b0, 32'h10, 4'hF, 32'h0, 1'b1, 1'b0, 32'h0);
        access(1, "R8", 1'b1, 1'b0, 32'h3C, 4'hF, 32'h0, 1'b1, 1'b0, 32'h0);

        // R7: back-to-back ROM writes each fault; word unchanged afterwards.
        access(1, "R7", 1'b1, 1'b1, 32'h4, 4'hF, 32'hFFFFFFFF, 1'b0, 1'b1, 32'h0);
        access(1, "R7", 1'b1, 1'b1, 32'h4, 4'h1, 32'h00000000, 1'b0, 1'b1, 32'h0);
        idle_check(1, "R9");
        access(1, "R7", 1'b1, 1'b0, 32'h4, 4'hF, 32'h0, 1'b1, 1'b0, 32'h0BADC0DE);

        // R3: out-of-range ROM write gets no fault, and a read gets no response.
        access(1, "R3", 1'b1, 1'b1, 32'h40, 4'hF, 32'h1, 1'b0, 1'b0, 32'h0);
        access(1, "R3", 1'b1, 1'b0, 32'h40, 4'hF, 32'h0, 1'b0, 1'b0, 32'h0);
        access(1, "R3", 1'b1, 1'b0, 32'h0,  4'hF, 32'h0, 1'b1, 1'b0, 32'hDEADBEEF);

        // R11: reset asserted with a read pending suppresses its response.
        rst_n = 1'b0;
        access(0, "R11", 1'b1, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        access(0, "R4", 1'b1, 1'b0, 32'h3FC, 4'hF, 32'h0, 1'b1, 1'b0, 32'hCAFEF00D);
        idle_check(0, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule